// File: doc/BRIEF.md
# I/O Port Window Address Translator

This block converts a 16-bit legacy I/O port number into a 32-bit address on a memory-mapped bus. A fixed table of port windows is searched in priority order. Depending on the window, the port number is either rebased onto a device's physical base (the address is the base plus the distance from the window's first port), or doubled and added to one shared base, which suits a peripheral whose byte registers sit on every other bus byte.

A port that lands in no window is steered to a fixed safe address, where writes are dropped and reads have no side effects, and a miss flag is raised alongside it. The translation is combinational and is captured in one output register stage, so a result appears one clock after its request, together with a valid flag that copies the request valid.

Top module: `iowin_xlate`

## Requirements
- R1: Ports 0x300 to 0x30F translate to 0xA7500000 + (port - 0x300), with the miss flag low.
- R2: Ports 0x290 to 0x293 translate to 0xA7700000 + (port - 0x290), with the miss flag low.
- R3: Ports 0x3F0 and 0x3F1 translate to 0xA7800000 + 2 * port, with the miss flag low.
- R4: Ports 0x1F0 to 0x1F7, 0x170 to 0x177, and the single ports 0x3F6 and 0x376 translate to 0xA7800000 + 2 * port, with the miss flag low.
- R5: Ports 0x3F8 to 0x407 and 0x2F8 to 0x307 translate to 0xA7800000 + 2 * port, with the miss flag low, except where a higher-priority window also covers the port.
- R6: Every port outside all windows translates to 0xFF000030 with the miss flag high; no hit ever produces 0xFF000030.
- R7: Windows are searched in the order rebase window 0x300, shared window 0x3F0, disk 1, disk 2, serial 1, serial 2, rebase window 0x290; the first match wins, so ports 0x300 to 0x307 take the R1 rebase mapping and not the R5 mapping.
- R8: out_valid equals in_valid of the previous cycle, and out_addr and out_miss for a request appear in the cycle after it is presented.
- R9: While in_valid is low, out_addr and out_miss keep their previous values whatever in_port holds.
- R10: Synchronous active-low reset clears out_valid, out_addr and out_miss to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A translation request is present on in_port |
| in_port | input | 16 | I/O port number to translate |
| out_valid | output | 1 | out_addr and out_miss carry a fresh result |
| out_addr | output | 32 | Translated bus address |
| out_miss | output | 1 | High when the port matched no window and the safe address was produced |

## Verification
On every cycle the assertions check the valid latency, that the result registers hold while no request is present, that a miss always carries the safe address and a hit never does, and that ports in the overlap of the 0x300 and 0x2F8 windows take the rebase mapping. The exact address of each window and the placement of each window edge are shown only by the bench, which sweeps all 65536 port numbers back to back and compares every result with an arithmetic model. The bench also covers the reset values and a run of idle cycles in which in_port changes.

// File: rtl/iowin_pkg.sv
// Package: shared widths, translation modes and the fixed window table.
// Assumes windows are listed in search priority order, index 0 first.
package iowin_pkg;

    localparam int unsigned PORT_W  = 16;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned NUM_WIN = 9;

    localparam logic [ADDR_W-1:0] SAFE_ADDR   = 32'hFF00_0030;
    localparam logic [ADDR_W-1:0] SHARED_BASE = 32'hA780_0000;

    typedef enum logic {
        XL_REBASE = 1'b0,   // base + (port - first port)
        XL_SPREAD = 1'b1    // shared base + 2 * port
    } xl_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] lo;
        logic [PORT_W-1:0] hi;
        xl_mode_e          mode;
        logic [ADDR_W-1:0] base;
    } win_desc_t;

    // Window table, priority order (lowest index wins).
    function automatic win_desc_t win_at(input int idx);
        win_desc_t w;
        case (idx)
            0: w = '{lo: 16'h0300, hi: 16'h030F, mode: XL_REBASE, base: 32'hA750_0000};
            1: w = '{lo: 16'h03F0, hi: 16'h03F1, mode: XL_SPREAD, base: SHARED_BASE};
            2: w = '{lo: 16'h01F0, hi: 16'h01F7, mode: XL_SPREAD, base: SHARED_BASE};
            3: w = '{lo: 16'h03F6, hi: 16'h03F6, mode: XL_SPREAD, base: SHARED_BASE};
            4: w = '{lo: 16'h0170, hi: 16'h0177, mode: XL_SPREAD, base: SHARED_BASE};
            5: w = '{lo: 16'h0376, hi: 16'h0376, mode: XL_SPREAD, base: SHARED_BASE};
            6: w = '{lo: 16'h03F8, hi: 16'h0407, mode: XL_SPREAD, base: SHARED_BASE};
            7: w = '{lo: 16'h02F8, hi: 16'h0307, mode: XL_SPREAD, base: SHARED_BASE};
            8: w = '{lo: 16'h0290, hi: 16'h0293, mode: XL_REBASE, base: 32'hA770_0000};
            default: w = '{lo: 16'hFFFF, hi: 16'h0000, mode: XL_REBASE, base: SAFE_ADDR};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/iowin_match.sv
// Module: one window comparator and its candidate address.
// Assumes LO <= HI; the candidate is meaningful only while hit is high.
module iowin_match
    import iowin_pkg::*;
#(
    parameter logic [PORT_W-1:0] LO   = '0,
    parameter logic [PORT_W-1:0] HI   = '0,
    parameter xl_mode_e          MODE = XL_REBASE,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [PORT_W-1:0] port,
    output logic              hit,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned PAD_REB = ADDR_W - PORT_W;
    localparam int unsigned PAD_SPR = ADDR_W - PORT_W - 1;

    logic [PORT_W-1:0] delta;

    // Range compare against the window bounds.
    always_comb begin
        hit = (port >= LO) && (port <= HI);
    end

    // Candidate address for the window's translation mode.
    generate
        if (MODE == XL_SPREAD) begin : g_spread
            assign delta = '0;
            always_comb begin
                addr = BASE + {{PAD_SPR{1'b0}}, port, 1'b0};
            end
        end else begin : g_rebase
            assign delta = port - LO;
            always_comb begin
                addr = BASE + {{PAD_REB{1'b0}}, delta};
            end
        end
    endgenerate

endmodule

// File: rtl/iowin_select.sv
// Module: instantiates every window comparator and picks the first hit.
// Assumes the package table is in priority order; no hit gives the safe address.
module iowin_select
    import iowin_pkg::*;
(
    input  logic [PORT_W-1:0] port,
    output logic [ADDR_W-1:0] addr,
    output logic              miss
);

    logic [NUM_WIN-1:0] hit_vec;
    logic [ADDR_W-1:0]  cand [NUM_WIN];

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            iowin_match #(
                .LO   (win_at(g).lo),
                .HI   (win_at(g).hi),
                .MODE (win_at(g).mode),
                .BASE (win_at(g).base)
            ) u_match (
                .port (port),
                .hit  (hit_vec[g]),
                .addr (cand[g])
            );
        end
    endgenerate

    // Priority pick: scan from the highest index down so index 0 wins last.
    always_comb begin
        addr = SAFE_ADDR;
        miss = 1'b1;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                addr = cand[i];
                miss = 1'b0;
            end
        end
    end

    // R6: a miss is reported exactly when no comparator fires.
    always_comb begin
        assert (miss == (hit_vec == '0))
            else $error("p_miss_nohit_r6: miss flag disagrees with comparators");
    end

endmodule

// File: rtl/iowin_outreg.sv
// Module: output register stage with a one-cycle valid pipeline.
// Assumes synchronous active-low reset; results load only on a valid request.
module iowin_outreg
    import iowin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_miss,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_miss
);

    // Valid flag follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Result registers load on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_miss <= 1'b0;
        end else if (d_valid) begin
            q_addr <= d_addr;
            q_miss <= d_miss;
        end
    end

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |=> q_valid);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> !q_valid);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> ($stable(q_addr) && $stable(q_miss)));

endmodule

// File: rtl/iowin_xlate.sv
// Module: top of the I/O port window translator.
// Combinational window search followed by one register stage; one result per
// valid request, one cycle later. Assumes synchronous active-low reset.
module iowin_xlate
    import iowin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_port,
    output logic              out_valid,
    output logic [31:0]       out_addr,
    output logic              out_miss
);

    logic [ADDR_W-1:0] xl_addr;
    logic              xl_miss;

    iowin_select u_select (
        .port (in_port),
        .addr (xl_addr),
        .miss (xl_miss)
    );

    iowin_outreg u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_addr  (xl_addr),
        .d_miss  (xl_miss),
        .q_valid (out_valid),
        .q_addr  (out_addr),
        .q_miss  (out_miss)
    );

    p_miss_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_miss) |-> (out_addr == SAFE_ADDR));
    p_hit_not_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_miss) |-> (out_addr != SAFE_ADDR));
    p_overlap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_port >= 16'h0300 && in_port <= 16'h0307)
        |=> (!out_miss && out_addr == 32'hA750_0000 + {16'h0000, $past(in_port)} - 32'h0000_0300));

endmodule

// File: tb/iowin_xlate_tb.sv
// Bench: sweeps every port number back to back and checks each result against
// an arithmetic model; also checks reset values and idle hold behaviour.
module iowin_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_port;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    iowin_xlate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_port   (in_port),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_miss  (out_miss)
    );

    // Model of the requirements: address, miss flag and requirement tag.
    function automatic void model(input logic [15:0] p, output logic [31:0] a,
                                  output logic m, output string tag);
        logic [31:0] pw = {16'h0000, p};
        m = 1'b0;
        if (pw >= 32'h300 && pw <= 32'h30F) begin
            a = 32'hA750_0000 + pw - 32'h300;
            tag = (pw <= 32'h307) ? "R7" : "R1";
        end else if (pw == 32'h3F0 || pw == 32'h3F1) begin
            a = 32'hA780_0000 + pw * 2; tag = "R3";
        end else if ((pw >= 32'h1F0 && pw <= 32'h1F7) || pw == 32'h3F6 ||
                     (pw >= 32'h170 && pw <= 32'h177) || pw == 32'h376) begin
            a = 32'hA780_0000 + pw * 2; tag = "R4";
        end else if ((pw >= 32'h3F8 && pw <= 32'h407) ||
                     (pw >= 32'h2F8 && pw <= 32'h307)) begin
            a = 32'hA780_0000 + pw * 2; tag = "R5";
        end else if (pw >= 32'h290 && pw <= 32'h293) begin
            a = 32'hA770_0000 + pw - 32'h290; tag = "R2";
        end else begin
            a = 32'hFF00_0030; m = 1'b1; tag = "R6";
        end
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    initial begin
        logic [31:0] ea;
        logic        em;
        string       tg;
        logic [31:0] held_a;
        logic        held_m;

        rst_n = 1'b0; in_valid = 1'b0; in_port = 16'h0300;
        repeat (3) @(negedge clk);
        // R10: reset values.
        check("R10", "out_valid", {31'b0, out_valid}, 32'h0);
        check("R10", "out_addr",  out_addr, 32'h0);
        check("R10", "out_miss",  {31'b0, out_miss},  32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R8: full sweep, one request per cycle, result one cycle later.
        for (int p = 0; p < 65536; p++) begin
            in_valid = 1'b1;
            in_port  = p[15:0];
            @(negedge clk);
            model(p[15:0], ea, em, tg);
            check("R8", "out_valid", {31'b0, out_valid}, 32'h1);
            check(tg, $sformatf("addr port 0x%04h", p), out_addr, ea);
            check(tg, $sformatf("miss port 0x%04h", p), {31'b0, out_miss}, {31'b0, em});
        end

        // R9 and R8: idle cycles with a changing port keep the last result.
        held_a = out_addr;
        held_m = out_miss;
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b0;
            in_port  = 16'h0300 + 16'(k);
            @(negedge clk);
            check("R8", "idle out_valid", {31'b0, out_valid}, 32'h0);
            check("R9", "idle out_addr",  out_addr, held_a);
            check("R9", "idle out_miss",  {31'b0, out_miss}, {31'b0, held_m});
        end

        // R4: a request after idle takes effect again.
        in_valid = 1'b1; in_port = 16'h0376;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4", "after idle addr", out_addr, 32'hA780_0000 + 32'h376 * 2);
        check("R8", "after idle valid", {31'b0, out_valid}, 32'h1);
        @(negedge clk);
        check("R8", "single pulse drop", {31'b0, out_valid}, 32'h0);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule